// File: doc/BRIEF.md
# Dual-Edge Capture Timer

The block times a digital input against a free-running count of system clocks. The input is brought into the clock domain through a short flop chain, and its transitions are found by comparing the synchronized level with its value one clock earlier. A high-to-low transition loads the current count into the falling-edge register. A low-to-high transition loads it into the rising-edge register. Both transitions raise a level interrupt request.

Software reads the two registers and subtracts them to obtain the pulse width and the period. Wrap-around is absorbed by modular subtraction. The interrupt stays raised until a one-cycle clear pulse. If a transition is captured while an earlier one is still unacknowledged, the register is overwritten and an overrun flag is set. The same clear pulse removes the overrun flag.

The input must stay at each level for at least 4 system clocks, which gives a minimum period of 8 clocks. Every capture, and the interrupt that goes with it, appears within 4 clocks of the transition.

Top module: `cap_timer`

## Requirements
- R1: After reset the count starts at 0 and rises by one on every clock. It wraps from all-ones to 0 with no other effect, so a capture taken across the wrap holds the wrapped value.
- R2: A high-to-low input transition loads `fall_cnt_o` with the count at the synchronizer's last sampling edge plus one. With the default two-stage synchronizer, that count is the value just before the third rising clock edge after the input change.
- R3: A low-to-high input transition loads `rise_cnt_o` in the same way.
- R4: The capture register and `irq_o` change on the third rising clock edge after the input change. That is within the 4-clock budget, and neither changes earlier.
- R5: `irq_o` is a level that rises with every capture and stays high until `clr_i` is sampled high. If a capture and a clear fall in the same cycle, `irq_o` stays high.
- R6: If a capture occurs while `irq_o` is high and `clr_i` is low in that cycle, `ovr_o` goes high and the register takes the new count. `clr_i` returns `ovr_o` to 0. A capture that coincides with a clear does not set `ovr_o`.
- R7: An input held 4 clocks high and 4 clocks low has every transition captured. The difference between the rising-edge and falling-edge registers equals the level time in clocks.
- R8: While `rst_ni` is low, both capture registers, `irq_o` and `ovr_o` are 0. The synchronizer resets to the low level.
- R9: A steady input captures nothing. Both registers keep their values, and `irq_o` stays low after a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_i | input | 1 | Asynchronous input to be measured |
| clr_i | input | 1 | One-cycle pulse that clears the interrupt and overrun |
| fall_cnt_o | output | CNT_W (16) | Count captured on the last high-to-low transition |
| rise_cnt_o | output | CNT_W (16) | Count captured on the last low-to-high transition |
| irq_o | output | 1 | Capture interrupt request, level |
| ovr_o | output | 1 | Capture overwritten before clear |

## Verification
The bench builds the block with its defaults: a 16-bit count and a two-stage synchronizer. With these values the whole counter range, including the wrap from 0xFFFF to 0, is crossed in about 65,000 clocks. The fixed three-edge capture latency can then be checked exactly, one clock before and at the loading edge. Random level times from 4 to 19 clocks exercise the minimum-width limit and ordinary widths. Directed runs cover overrun and a clear that coincides with a capture.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_ev_t;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det
  import cap_timer_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     lvl_i,
  output edge_ev_t ev_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign ev_o.rise = lvl_i & ~prev_q;
  assign ev_o.fall = ~lvl_i & prev_q;
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;  // wraps silently
  end
endmodule

// File: rtl/cap_capture.sv
module cap_capture
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  edge_ev_t         ev_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] fall_cnt_o,
  output logic [CNT_W-1:0] rise_cnt_o,
  output logic             irq_o,
  output logic             ovr_o
);
  logic any_ev;
  logic irq_d, ovr_d;

  assign any_ev = ev_i.rise | ev_i.fall;

  always_comb begin
    irq_d = irq_o;
    if (clr_i)  irq_d = 1'b0;
    if (any_ev) irq_d = 1'b1;  // capture beats clear
  end

  always_comb begin
    ovr_d = ovr_o | (any_ev & irq_o);
    if (clr_i) ovr_d = 1'b0;   // acknowledged pending is not an overrun
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_cnt_o <= '0;
      rise_cnt_o <= '0;
      irq_o      <= 1'b0;
      ovr_o      <= 1'b0;
    end else begin
      if (ev_i.fall) fall_cnt_o <= cnt_i;
      if (ev_i.rise) rise_cnt_o <= cnt_i;
      irq_o <= irq_d;
      ovr_o <= ovr_d;
    end
  end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] fall_cnt_o,
  output logic [CNT_W-1:0] rise_cnt_o,
  output logic             irq_o,
  output logic             ovr_o
);
  logic             cap_sync;
  edge_ev_t         edge_ev;
  logic [CNT_W-1:0] cnt_q;
  logic             rise_ev, fall_ev;

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cap_i),
    .q_o   (cap_sync)
  );

  cap_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (cap_sync),
    .ev_o  (edge_ev)
  );

  cap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt_q)
  );

  cap_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (edge_ev),
    .cnt_i     (cnt_q),
    .clr_i     (clr_i),
    .fall_cnt_o(fall_cnt_o),
    .rise_cnt_o(rise_cnt_o),
    .irq_o     (irq_o),
    .ovr_o     (ovr_o)
  );

  assign rise_ev = edge_ev.rise;
  assign fall_ev = edge_ev.fall;
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             rise_i,
  input logic             fall_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] fall_cnt_i,
  input logic [CNT_W-1:0] rise_cnt_i,
  input logic             irq_i,
  input logic             ovr_i
);
  a_r1_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  a_r2_fall_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> fall_cnt_i == $past(cnt_i));

  a_r3_rise_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> rise_cnt_i == $past(cnt_i));

  a_r5_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i || fall_i) |=> irq_i);

  a_r5_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !clr_i) |=> irq_i);

  a_r6_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !clr_i && (rise_i || fall_i)) |=> ovr_i);

  a_r6_ovr_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ovr_i);

  a_r9_fall_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(fall_cnt_i));

  a_r9_rise_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(rise_cnt_i));
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .rise_i    (rise_ev),
  .fall_i    (fall_ev),
  .cnt_i     (cnt_q),
  .fall_cnt_i(fall_cnt_o),
  .rise_cnt_i(rise_cnt_o),
  .irq_i     (irq_o),
  .ovr_i     (ovr_o)
);

// File: tb/sim_cap_timer.sv
`timescale 1ns/1ps
module sim_cap_timer;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cap = 1'b0;
  logic             clr = 1'b0;
  logic [CNT_W-1:0] fall_cnt, rise_cnt;
  logic             irq, ovr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [CNT_W-1:0] bcnt;
  logic [CNT_W-1:0] m_fall = '0, m_rise = '0;
  logic             m_irq = 1'b0, m_ovr = 1'b0;

  always #2 clk = ~clk;

  cap_timer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cap_i(cap), .clr_i(clr),
    .fall_cnt_o(fall_cnt), .rise_cnt_o(rise_cnt), .irq_o(irq), .ovr_o(ovr)
  );

  // bench-side cycle count since reset release
  always @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= bcnt + 1'b1;

  function automatic logic [CNT_W-1:0] exp_cap(input logic [CNT_W-1:0] m);
    return m + 16'd2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // mode 0: no clear, 1: clear after capture, 2: clear coincident with capture
  task automatic do_edge(input logic v, input int width, input int mode, input string tag);
    logic [CNT_W-1:0] e;
    logic             ovr_next;
    @(negedge clk);
    clr = 1'b0;
    e = exp_cap(bcnt);
    cap = v;
    for (int i = 1; i < width; i++) begin
      @(negedge clk);
      if (i == 2) begin
        chk({tag, " R4 early fall"}, fall_cnt, m_fall);
        chk({tag, " R4 early rise"}, rise_cnt, m_rise);
        chk({tag, " R4 early irq"}, irq, m_irq);
        if (mode == 2) clr = 1'b1;
      end
      if (i == 3) begin
        ovr_next = (mode == 2) ? 1'b0 : (m_ovr | m_irq);
        if (v) m_rise = e; else m_fall = e;
        m_irq = 1'b1;
        m_ovr = ovr_next;
        if (v) chk({tag, " R3 rise capture"}, rise_cnt, e);
        else   chk({tag, " R2 fall capture"}, fall_cnt, e);
        chk({tag, " R5 irq"}, irq, 1'b1);
        chk({tag, " R6 ovr"}, ovr, m_ovr);
        clr = 1'b0;
        if (mode == 1) begin
          clr = 1'b1;
          m_irq = 1'b0;
          m_ovr = 1'b0;
        end
      end
      if (i == 4) clr = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset fall", fall_cnt, 0);
    chk("R8 reset rise", rise_cnt, 0);
    chk("R8 reset irq", irq, 0);
    chk("R8 reset ovr", ovr, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7 minimum widths, 4 high 4 low
    for (int k = 0; k < 3; k++) begin
      do_edge(1'b1, 4, 1, "R7 min high");
      do_edge(1'b0, 4, 1, "R7 min low");
      chk("R7 width", 32'(CNT_W'(fall_cnt - rise_cnt)), 4);
    end

    // random widths
    for (int k = 0; k < 40; k++) begin
      int wh, wl;
      wh = 4 + int'($urandom_range(15));
      wl = 4 + int'($urandom_range(15));
      do_edge(1'b1, wh, 1, "R3 rand");
      do_edge(1'b0, wl, 1, "R2 rand");
      chk("R7 rand width", 32'(CNT_W'(fall_cnt - rise_cnt)), 32'(wh));
    end

    // R9 steady input
    repeat (30) @(negedge clk);
    chk("R9 steady fall", fall_cnt, m_fall);
    chk("R9 steady rise", rise_cnt, m_rise);
    chk("R9 steady irq", irq, 0);

    // R6 overrun: two captures without clear
    do_edge(1'b1, 6, 0, "R6 first");
    do_edge(1'b0, 6, 0, "R6 second");
    chk("R6 overrun set", ovr, 1);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    m_irq = 1'b0; m_ovr = 1'b0;
    chk("R5 clear irq", irq, 0);
    chk("R6 clear ovr", ovr, 0);

    // R5 capture coincident with clear, with a pending request
    do_edge(1'b1, 6, 0, "R5 pend");
    do_edge(1'b0, 6, 2, "R5 coincide");
    chk("R5 coincide irq kept", irq, 1);
    chk("R6 coincide no ovr", ovr, 0);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    m_irq = 1'b0; m_ovr = 1'b0;

    // R1 wrap: capture at count 0xFFFF+1
    while (bcnt != 16'hFFFD) @(negedge clk);
    do_edge(1'b1, 6, 1, "R1 wrap");
    chk("R1 wrap value", rise_cnt, 0);
    do_edge(1'b0, 6, 1, "R1 after wrap");
    chk("R1 wrap width", 32'(CNT_W'(fall_cnt - rise_cnt)), 6);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule